// File: doc/BRIEF.md
# Configuration Base Address Register Bank

This block holds the Base Address Registers of one function's configuration space. Each of up to six slots is fixed at elaboration as unimplemented, an I/O window, a 32-bit memory window or a 64-bit memory window, with a power-of-two size. Software discovers a window's size by writing all ones and reading back: only the address bits at or above the size can be written, the type bits are constant, and everything below the size reads zero. Software then programs the base address. A 64-bit memory window occupies two consecutive slots. The second slot holds the upper 32 address bits.

Accesses are dword-wide and arrive on a request channel with valid/ready. Each request carries a byte offset, byte enables and, for writes, data. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. A read returns its dword one cycle later on a response channel with valid/ready. A write completes on acceptance and produces no response. Back-pressure works as follows. While a response is held with `rsp_ready` low, `req_ready` stays low and the response holds still. When the response is taken, a new request can be accepted in the same cycle. A header-type parameter sets how many slots exist.

Top module: `pci_bar_bank`

## Requirements
- R1: After reset every address bit is zero, so each slot reads back only its type bits, and no response is pending.
- R2: Type bits are hardwired. An I/O slot reads bit 0 = 1 and bit 1 = 0. A memory slot reads bit 0 = 0, bits 2:1 = 00 for a 32-bit window or 10 for the low slot of a 64-bit window, and bit 3 = its prefetchable parameter.
- R3: Only address bits at or above log2(size) are writable. The smallest size is 4 bytes for I/O and 16 bytes for memory. Writing all ones reads back ones in exactly those bits plus the type bits. Clearing the flag bits (1:0 for I/O, 3:0 for memory), inverting and adding one gives the size.
- R4: Byte lane b (bits 8b+7:8b) is updated only when byte-enable bit b is 1. A write with no enables changes nothing.
- R5: An unimplemented slot reads all zeros and ignores writes.
- R6: A 64-bit window's next slot holds the upper address. Below 4 GiB all 32 upper bits are writable. At 4 GiB or more, the low slot's address bits read zero and the upper slot is writable only from bit log2(size)-32 up.
- R7: Slot i sits at byte offset 0x10 + 4*i. Header type 0 has six slots, type 1 has two and type 2 has one. Any other offset, including a slot beyond the header's count, reads zero and ignores writes. Offset bits 1:0 are ignored.
- R8: A read accepted in one cycle presents its data with `rsp_valid` high from the next cycle. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` and `rsp_valid` hold and `req_ready` is low. Writes raise no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Configuration byte offset |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 32 | Read data |

## Verification
The following faults all show up in the value returned by the first read after the write that exposes them:
- a corrupted size mask, which lets a low address bit stick or blocks a high one;
- a wrong type pattern;
- a byte lane that ignores its enable;
- a 64-bit pairing that picks the wrong slot.

The bench writes all ones and partial patterns to every kind of slot and reads each back at once, so such a fault appears one cycle after the read is accepted. A response register that advances under back-pressure shows up at the ports within a single stalled cycle as changed data or a raised `req_ready`.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;

  localparam int MAX_SLOTS = 6;
  localparam logic [7:0] FIRST_OFFSET = 8'h10;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_IO    = 2'd1,
    KIND_MEM32 = 2'd2,
    KIND_MEM64 = 2'd3
  } bar_kind_e;

  function automatic int slots_for_header(input int hdr);
    case (hdr)
      0:       return 6;
      1:       return 2;
      default: return 1;
    endcase
  endfunction

  // A slot is the upper half when the slot below opens a 64-bit window
  // and is not itself an upper half.
  function automatic bit is_upper_half(input logic [2*MAX_SLOTS-1:0] kinds, input int idx);
    bit up;
    up = 1'b0;
    for (int j = 0; j < idx; j++)
      up = !up && (kinds[2*j +: 2] == KIND_MEM64);
    return up;
  endfunction

  function automatic int slot_log2(input logic [6*MAX_SLOTS-1:0] sizes, input int idx, input bit up);
    int src;
    src = (up && idx > 0) ? idx - 1 : idx;
    return int'(sizes[6*src +: 6]);
  endfunction

  function automatic logic [31:0] addr_mask(input logic [1:0] kind, input int lg, input bit up);
    logic [63:0] full;
    int l;
    l = lg;
    if (up) begin
      if (l < 4)  l = 4;
      if (l > 63) l = 63;
      full = ~((64'd1 << l) - 64'd1);
      return full[63:32];
    end
    case (kind)
      KIND_IO: begin
        if (l < 2)  l = 2;
        if (l > 31) l = 31;
      end
      KIND_MEM32: begin
        if (l < 4)  l = 4;
        if (l > 31) l = 31;
      end
      KIND_MEM64: begin
        if (l < 4)  l = 4;
        if (l > 63) l = 63;
      end
      default: return 32'h0;
    endcase
    full = ~((64'd1 << l) - 64'd1);
    return full[31:0];
  endfunction

  function automatic logic [31:0] type_bits(input logic [1:0] kind, input bit pref, input bit up);
    if (up) return 32'h0;
    case (kind)
      KIND_IO:    return 32'h1;
      KIND_MEM32: return {28'h0, pref, 3'b000};
      KIND_MEM64: return {28'h0, pref, 3'b100};
      default:    return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/bar_slot_decode.sv
module bar_slot_decode
  import bar_bank_pkg::*;
#(
  parameter int NUM_SLOTS = 6
) (
  input  logic [7:0]           addr,
  output logic [NUM_SLOTS-1:0] hit,
  output logic                 in_range
);

  localparam logic [7:0] SPAN = 8'(4 * NUM_SLOTS);

  logic [7:0] rel;
  logic       unused_lsb;

  assign rel        = addr - FIRST_OFFSET;
  assign in_range   = (addr >= FIRST_OFFSET) && (rel < SPAN);
  assign unused_lsb = ^rel[1:0];

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_hit
    assign hit[i] = in_range && (rel[7:2] == 6'(i));
  end

  always_comb begin
    // R7
    hit_onehot_chk: assert ($onehot0(hit));
    // R7
    if (!in_range) begin
      hit_none_chk: assert (hit == '0);
    end
  end

endmodule

// File: rtl/bar_slot_reg.sv
module bar_slot_reg #(
  parameter logic [31:0] WMASK = 32'h0,
  parameter logic [31:0] FIXED = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);

  logic [31:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) q[8*b +: 8] <= wdata[8*b +: 8] & WMASK[8*b +: 8];
    end
  end

  assign rdata = q | FIXED;

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rdata));

  for (genvar b = 0; b < 4; b++) begin : g_lane
    // R4
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !be[b]) |=> $stable(rdata[8*b +: 8]));
  end

endmodule

// File: rtl/pci_bar_bank.sv
module pci_bar_bank
  import bar_bank_pkg::*;
#(
  parameter int                          HDR_TYPE  = 0,
  parameter logic [2*MAX_SLOTS-1:0]      SLOT_KIND = 12'h0CD,
  parameter logic [6*MAX_SLOTS-1:0]      SLOT_LOG2 = {6'd0, 6'd0, 6'd20, 6'd0, 6'd33, 6'd5},
  parameter logic [MAX_SLOTS-1:0]        SLOT_PREF = 6'b001000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_data
);

  localparam int NUM_SLOTS = slots_for_header(HDR_TYPE);

  logic                 req_fire;
  logic [NUM_SLOTS-1:0] slot_hit;
  logic                 addr_ok;
  logic [31:0]          slot_rd [NUM_SLOTS];
  logic [31:0]          rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  bar_slot_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
    .addr     (req_addr),
    .hit      (slot_hit),
    .in_range (addr_ok)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam bit          UP   = is_upper_half(SLOT_KIND, i);
    localparam logic [1:0]  KIND = SLOT_KIND[2*i +: 2];
    localparam int          LG   = slot_log2(SLOT_LOG2, i, UP);
    localparam logic [31:0] WM   = addr_mask(KIND, LG, UP);
    localparam logic [31:0] FX   = type_bits(KIND, SLOT_PREF[i], UP);

    if (UP || KIND != KIND_NONE) begin : g_reg
      bar_slot_reg #(.WMASK(WM), .FIXED(FX)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (req_fire && req_write && slot_hit[i]),
        .be    (req_be),
        .wdata (req_wdata),
        .rdata (slot_rd[i])
      );
    end else begin : g_none
      assign slot_rd[i] = '0;
      // R5
      none_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && !req_write && slot_hit[i]) |=> (rsp_data == '0));
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (slot_hit[i]) rd_mux = rd_mux | slot_rd[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (req_fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R7
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && !req_write && !addr_ok) |=> (rsp_valid && rsp_data == '0));

endmodule

// File: tb/test_pci_bar_bank.sv
`timescale 1ns/1ps
module test_pci_bar_bank;

  typedef struct {
    logic [31:0] d;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        a_req_valid = 0, a_req_write = 0, a_rsp_ready = 1;
  logic [7:0]  a_req_addr = 0;
  logic [3:0]  a_req_be = 0;
  logic [31:0] a_req_wdata = 0;
  logic        a_req_ready, a_rsp_valid;
  logic [31:0] a_rsp_data;

  logic        b_req_valid = 0, b_req_write = 0, b_rsp_ready = 1;
  logic [7:0]  b_req_addr = 0;
  logic [3:0]  b_req_be = 0;
  logic [31:0] b_req_wdata = 0;
  logic        b_req_ready, b_rsp_valid;
  logic [31:0] b_rsp_data;

  // Bank A: header 0. Slot0 I/O 32 B, slots 1-2 64-bit 8 GiB,
  // slots 3-4 64-bit 1 MiB prefetchable, slot5 unimplemented.
  pci_bar_bank #(
    .HDR_TYPE (0),
    .SLOT_KIND(12'h0CD),
    .SLOT_LOG2({6'd0, 6'd0, 6'd20, 6'd0, 6'd33, 6'd5}),
    .SLOT_PREF(6'b001000)
  ) i_pci_bar_bank (
    .clk(clk), .rst_n(rst_n),
    .req_valid(a_req_valid), .req_ready(a_req_ready), .req_write(a_req_write),
    .req_addr(a_req_addr), .req_be(a_req_be), .req_wdata(a_req_wdata),
    .rsp_valid(a_rsp_valid), .rsp_ready(a_rsp_ready), .rsp_data(a_rsp_data)
  );

  // Bank B: header 1. Slot0 32-bit memory 4 KiB, slot1 unimplemented,
  // slots 2-5 configured but beyond the header's count.
  pci_bar_bank #(
    .HDR_TYPE (1),
    .SLOT_KIND(12'hAA2),
    .SLOT_LOG2({6{6'd12}}),
    .SLOT_PREF(6'b000000)
  ) i_pci_bar_bank_bridge (
    .clk(clk), .rst_n(rst_n),
    .req_valid(b_req_valid), .req_ready(b_req_ready), .req_write(b_req_write),
    .req_addr(b_req_addr), .req_be(b_req_be), .req_wdata(b_req_wdata),
    .rsp_valid(b_rsp_valid), .rsp_ready(b_rsp_ready), .rsp_data(b_rsp_data)
  );

  int   tests = 0;
  int   fails = 0;
  bit   done  = 0;
  exp_t qa[$];
  exp_t qb[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] ex);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, ex);
    end
  endtask

  // Driver: pushes the expected read data into the scoreboard, then issues.
  task automatic acc(input bit inst, input bit wr, input logic [7:0] a, input logic [3:0] be,
                     input logic [31:0] wd, input logic [31:0] ex, input string tag);
    exp_t e;
    e.d = ex;
    e.tag = tag;
    if (!wr) begin
      if (inst) qb.push_back(e); else qa.push_back(e);
    end
    @(negedge clk);
    if (inst) begin
      b_req_valid = 1; b_req_write = wr; b_req_addr = a; b_req_be = be; b_req_wdata = wd;
      while (!b_req_ready) @(negedge clk);
    end else begin
      a_req_valid = 1; a_req_write = wr; a_req_addr = a; a_req_be = be; a_req_wdata = wd;
      while (!a_req_ready) @(negedge clk);
    end
    @(posedge clk);
    #1;
    a_req_valid = 0;
    b_req_valid = 0;
  endtask

  // Monitor: compares every handed-over response with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && a_rsp_valid && a_rsp_ready) begin
      if (qa.size() == 0) chk(1'b0, "R8 unexpected response A", a_rsp_data, 32'h0);
      else begin
        exp_t e;
        e = qa.pop_front();
        chk(a_rsp_data === e.d, e.tag, a_rsp_data, e.d);
      end
    end
    if (rst_n && b_rsp_valid && b_rsp_ready) begin
      if (qb.size() == 0) chk(1'b0, "R8 unexpected response B", b_rsp_data, 32'h0);
      else begin
        exp_t e;
        e = qb.pop_front();
        chk(b_rsp_data === e.d, e.tag, b_rsp_data, e.d);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(a_rsp_valid == 0, "R1 no response after reset", 32'(a_rsp_valid), 32'h0);
    chk(a_req_ready == 1, "R8 ready after reset", 32'(a_req_ready), 32'h1);

    // R1 / R2: reset reads show type bits only
    acc(0, 0, 8'h10, 4'hF, 0, 32'h0000_0001, "R1 R2 io reset");
    acc(0, 0, 8'h14, 4'hF, 0, 32'h0000_0004, "R1 R2 mem64 reset");
    acc(0, 0, 8'h18, 4'hF, 0, 32'h0000_0000, "R1 upper reset");
    acc(0, 0, 8'h1C, 4'hF, 0, 32'h0000_000C, "R1 R2 mem64 pref reset");
    acc(0, 0, 8'h20, 4'hF, 0, 32'h0000_0000, "R1 upper2 reset");
    acc(1, 0, 8'h10, 4'hF, 0, 32'h0000_0000, "R1 R2 mem32 reset");

    // R3: size probing; I/O 32 B -> ~FFFFFFE0+1 = 0x20
    acc(0, 1, 8'h10, 4'hF, 32'hFFFF_FFFF, 0, "");
    acc(0, 0, 8'h10, 4'hF, 0, 32'hFFFF_FFE1, "R3 io size mask");
    acc(0, 1, 8'h10, 4'hF, 32'h0000_005F, 0, "");
    acc(0, 0, 8'h10, 4'hF, 0, 32'h0000_0041, "R3 io low bits dropped");
    acc(1, 1, 8'h10, 4'hF, 32'hFFFF_FFFF, 0, "");
    acc(1, 0, 8'h10, 4'hF, 0, 32'hFFFF_F000, "R3 mem32 size mask");

    // R6: 8 GiB window -> low address bits zero, upper from bit 1
    acc(0, 1, 8'h14, 4'hF, 32'hFFFF_FFFF, 0, "");
    acc(0, 0, 8'h14, 4'hF, 0, 32'h0000_0004, "R6 large low slot");
    acc(0, 1, 8'h18, 4'hF, 32'hFFFF_FFFF, 0, "");
    acc(0, 0, 8'h18, 4'hF, 0, 32'hFFFF_FFFE, "R6 large upper slot");
    acc(0, 1, 8'h20, 4'hF, 32'hDEAD_BEEF, 0, "");
    acc(0, 0, 8'h20, 4'hF, 0, 32'hDEAD_BEEF, "R6 small upper fully writable");

    // R4: byte enables on 1 MiB window (mask FFF00000)
    acc(0, 1, 8'h1C, 4'b1000, 32'h1234_5678, 0, "");
    acc(0, 0, 8'h1C, 4'hF, 0, 32'h1200_000C, "R4 lane3 only");
    acc(0, 1, 8'h1C, 4'b0100, 32'hFFFF_FFFF, 0, "");
    acc(0, 0, 8'h1C, 4'hF, 0, 32'h12F0_000C, "R4 lane2 only");
    acc(0, 1, 8'h1C, 4'b0000, 32'h0000_0000, 0, "");
    acc(0, 0, 8'h1C, 4'hF, 0, 32'h12F0_000C, "R4 no enables");

    // R5: unimplemented slots
    acc(0, 1, 8'h24, 4'hF, 32'hFFFF_FFFF, 0, "");
    acc(0, 0, 8'h24, 4'hF, 0, 32'h0000_0000, "R5 unimplemented A");
    acc(1, 1, 8'h14, 4'hF, 32'hFFFF_FFFF, 0, "");
    acc(1, 0, 8'h14, 4'hF, 0, 32'h0000_0000, "R5 unimplemented B");

    // R7: offsets outside the slots, and header limit
    acc(0, 1, 8'h28, 4'hF, 32'hFFFF_FFFF, 0, "");
    acc(0, 1, 8'h0C, 4'hF, 32'h0000_0000, 0, "");
    acc(0, 0, 8'h28, 4'hF, 0, 32'h0000_0000, "R7 offset 0x28");
    acc(0, 0, 8'h0C, 4'hF, 0, 32'h0000_0000, "R7 offset 0x0C");
    acc(0, 0, 8'hFC, 4'hF, 0, 32'h0000_0000, "R7 offset 0xFC");
    acc(0, 0, 8'h13, 4'hF, 0, 32'h0000_0041, "R7 slot0 untouched, lsb ignored");
    acc(1, 1, 8'h18, 4'hF, 32'hFFFF_FFFF, 0, "");
    acc(1, 0, 8'h18, 4'hF, 0, 32'h0000_0000, "R7 beyond header count");
    acc(1, 0, 8'h10, 4'hF, 0, 32'hFFFF_F000, "R7 bridge slot0 untouched");

    // R8: back-pressure on bank A
    while (qa.size() != 0 || qb.size() != 0) @(negedge clk);
    @(posedge clk);
    #1 a_rsp_ready = 0;
    acc(0, 0, 8'h1C, 4'hF, 0, 32'h12F0_000C, "R8 stalled response");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(a_rsp_valid == 1, "R8 valid held", 32'(a_rsp_valid), 32'h1);
      chk(a_req_ready == 0, "R8 ready low in stall", 32'(a_req_ready), 32'h0);
      chk(a_rsp_data == 32'h12F0_000C, "R8 data held", a_rsp_data, 32'h12F0_000C);
    end
    @(posedge clk);
    #1 a_rsp_ready = 1;
    acc(0, 1, 8'h10, 4'hF, 32'h0000_0080, 0, "");
    @(negedge clk);
    chk(a_rsp_valid == 0, "R8 write gives no response", 32'(a_rsp_valid), 32'h0);
    acc(0, 0, 8'h10, 4'hF, 0, 32'h0000_0081, "R8 after stall");

    while (qa.size() != 0 || qb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule